// File: doc/BRIEF.md
# Vector and Floating-Point Load Decoder

This block is a single registered decode stage for the load-floating-point major opcode of a 32-bit instruction stream. Each cycle that `valid_i` is high, it accepts one uncompressed instruction word. On the next clock edge it reports one of two classes: a scalar floating-point load, or a vector load. For a vector load it also reports the addressing mode, the element size, the segment or register count, the mask bit and the register fields.

Words in this space that are reserved, or that break a per-variant rule, raise `illegal_o` instead of a class. Per-variant rules include unmasked whole-register and mask loads, the alignment of whole-register groups, and the extended-width reservation. An enable input per floating-point precision and one enable input for vectors let the surrounding core turn off parts of the space. Words with any other opcode pass through as neither class and not illegal, so a later decode stage can claim them.

The output registers load only on valid cycles and hold their contents otherwise. `valid_o` is the one-cycle-delayed copy of `valid_i`.

Top module: `vfload_decoder`

## Requirements
- R1: A word whose bits [6:0] differ from 0000111 gives is_fp_o = is_vec_o = illegal_o = 0 and all field outputs zero.
- R2: Width field [14:12] values 1, 2, 3 and 4 are scalar loads. size_o gives log2 of the byte size, which equals the width value. imm_o is bits [31:20] sign-extended to XLEN. rd_o = [11:7] and rs1_o = [19:15]. mode_o, nfields_o, vm_o and rs2_o are zero. Bit 28 does not affect scalar decode.
- R3: A scalar width whose precision bit in ext_en_i is 0 is illegal. The bits are: bit 0 half (width 1), bit 1 single, bit 2 double, bit 3 quad (width 4).
- R4: Width values 0, 5, 6 and 7 are vector loads with size_o 0, 1, 2 and 3 (8/16/32/64-bit elements). nfields_o = nf[31:29] + 1, vm_o = bit 25, rd_o = vd, imm_o = 0. If vec_en_i is 0, these widths are illegal.
- R5: Bit 28 set with a vector width value is illegal.
- R6: The mop field [27:26] selects the mode: 01 indexed-unordered (mode 1), 10 strided (mode 2), 11 indexed-ordered (mode 3). For these, rs2_o = bits [24:20]. For mop 00, rs2_o = 0.
- R7: For mop 00, bits [24:20] select the sub-mode: 00000 unit-stride (mode 0), 01000 whole-register (mode 4), 01011 mask (mode 5), 10000 fault-only-first (mode 6). Any other value is illegal.
- R8: A whole-register load is illegal if vm = 0, if nf is not 0, 1, 3 or 7, or if vd is not a multiple of nf + 1.
- R9: A mask load is illegal if vm = 0 or if nf is non-zero.
- R10: An illegal word gives illegal_o = 1 with is_fp_o, is_vec_o and every field output zero. At most one of is_fp_o, is_vec_o and illegal_o is ever high.
- R11: Outputs appear one cycle after a valid input, and valid_o equals valid_i delayed by one cycle. On cycles with valid_i low, all decode outputs hold.
- R12: An active-low asynchronous reset clears valid_o, illegal_o and every decode output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word valid |
| instr_i | input | 32 | Instruction word |
| ext_en_i | input | 4 | Scalar precision enables: half, single, double, quad (bit 0 to 3) |
| vec_en_i | input | 1 | Vector loads enabled |
| valid_o | output | 1 | Decode result valid |
| is_fp_o | output | 1 | Legal scalar floating-point load |
| is_vec_o | output | 1 | Legal vector load |
| illegal_o | output | 1 | Reserved or disallowed encoding in this opcode space |
| mode_o | output | 3 | Vector addressing mode code (see R6, R7) |
| size_o | output | 3 | log2 of element or operand size in bytes |
| nfields_o | output | 4 | Segment count or whole-register count (nf + 1) |
| vm_o | output | 1 | Vector mask bit (1 = unmasked) |
| rd_o | output | 5 | Destination register |
| rs1_o | output | 5 | Base address register |
| rs2_o | output | 5 | Stride register or index vector register |
| imm_o | output | XLEN | Sign-extended scalar offset |

## Verification
The bench aims at encodings that differ from a legal form by a single bit. These include a whole-register word with the mask bit cleared, a mask load with a non-zero segment field, and whole-register groups with a vd that is not a multiple of the group size. Getting any of these wrong would let an undefined operation reach execution as a valid load.

It also sets bit 28 on both vector and scalar widths. A decoder that reserved the bit across the whole space would reject legal scalar loads whose offset happens to have that bit set. Another that ignored the bit would accept reserved vector widths.

Disabled precisions and a disabled vector unit are exercised to confirm they flag instead of decoding. Idle cycles between words confirm that the outputs do not move when nothing new arrives.

// File: rtl/vfload_pkg.sv
package vfload_pkg;
  localparam logic [6:0] OPC_LOAD_FP = 7'b0000111;
  localparam int NUM_FP_EXT = 4;

  localparam logic [4:0] SUB_PLAIN = 5'b00000;
  localparam logic [4:0] SUB_WHOLE = 5'b01000;
  localparam logic [4:0] SUB_MASK  = 5'b01011;
  localparam logic [4:0] SUB_FOF   = 5'b10000;

  typedef enum logic [2:0] {
    MODE_UNIT      = 3'd0,
    MODE_IDX_UNORD = 3'd1,
    MODE_STRIDED   = 3'd2,
    MODE_IDX_ORD   = 3'd3,
    MODE_WHOLE     = 3'd4,
    MODE_MASK      = 3'd5,
    MODE_FOF       = 3'd6
  } ld_mode_e;

  // bit order matches the instruction word
  typedef struct packed {
    logic [2:0] nf;
    logic       mew;
    logic [1:0] mop;
    logic       vm;
    logic [4:0] sub;
    logic [4:0] rs1;
    logic [2:0] width;
    logic [4:0] rd;
    logic [6:0] opc;
  } ld_word_t;

  typedef struct packed {
    logic       is_fp;
    logic       is_vec;
    logic       illegal;
    ld_mode_e   mode;
    logic [2:0] size;
    logic [3:0] nfields;
    logic       vm;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
  } dec_res_t;
endpackage

// File: rtl/vfload_split.sv
module vfload_split
  import vfload_pkg::*;
(
  input  logic [31:0] instr_i,
  output ld_word_t    word_o,
  output logic        in_space_o,
  output logic        fp_width_o,
  output logic [1:0]  eew_o
);
  assign word_o     = ld_word_t'(instr_i);
  assign in_space_o = (word_o.opc == OPC_LOAD_FP);
  assign fp_width_o = (word_o.width >= 3'd1) && (word_o.width <= 3'd4);

  always_comb begin
    unique case (word_o.width)
      3'd5:    eew_o = 2'd1;
      3'd6:    eew_o = 2'd2;
      3'd7:    eew_o = 2'd3;
      default: eew_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/vfload_vcheck.sv
module vfload_vcheck
  import vfload_pkg::*;
(
  input  ld_word_t word_i,
  input  logic     vec_en_i,
  output ld_mode_e mode_o,
  output logic     bad_o
);
  logic grp_ok;

  // group size nf+1 must be a power of two up to 8
  assign grp_ok = (word_i.nf == 3'd0) || (word_i.nf == 3'd1) ||
                  (word_i.nf == 3'd3) || (word_i.nf == 3'd7);

  always_comb begin
    bad_o  = !vec_en_i || word_i.mew;
    mode_o = MODE_UNIT;
    unique case (word_i.mop)
      2'b01: mode_o = MODE_IDX_UNORD;
      2'b10: mode_o = MODE_STRIDED;
      2'b11: mode_o = MODE_IDX_ORD;
      default: begin
        unique case (word_i.sub)
          SUB_PLAIN: mode_o = MODE_UNIT;
          SUB_FOF:   mode_o = MODE_FOF;
          SUB_WHOLE: begin
            mode_o = MODE_WHOLE;
            // alignment: low vd bits covered by nf must be clear
            if (!word_i.vm || !grp_ok || ((word_i.rd[2:0] & word_i.nf) != 3'd0))
              bad_o = 1'b1;
          end
          SUB_MASK: begin
            mode_o = MODE_MASK;
            if (!word_i.vm || (word_i.nf != 3'd0)) bad_o = 1'b1;
          end
          default: bad_o = 1'b1;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/vfload_decoder.sv
module vfload_decoder
  import vfload_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [3:0]      ext_en_i,
  input  logic            vec_en_i,
  output logic            valid_o,
  output logic            is_fp_o,
  output logic            is_vec_o,
  output logic            illegal_o,
  output logic [2:0]      mode_o,
  output logic [2:0]      size_o,
  output logic [3:0]      nfields_o,
  output logic            vm_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [XLEN-1:0] imm_o
);
  localparam int IMM_W = 12;

  ld_word_t        word;
  logic            in_space, fp_width;
  logic [1:0]      eew;
  ld_mode_e        vmode;
  logic            vbad;
  logic [NUM_FP_EXT-1:0] fp_hit;
  logic            fp_ok;
  dec_res_t        res_d, res_q;
  logic [XLEN-1:0] imm_d, imm_q;
  logic            valid_q;

  vfload_split u_split (
    .instr_i    (instr_i),
    .word_o     (word),
    .in_space_o (in_space),
    .fp_width_o (fp_width),
    .eew_o      (eew)
  );

  vfload_vcheck u_vcheck (
    .word_i   (word),
    .vec_en_i (vec_en_i),
    .mode_o   (vmode),
    .bad_o    (vbad)
  );

  // one enable lane per scalar precision; width value i+1 maps to lane i
  for (genvar i = 0; i < NUM_FP_EXT; i++) begin : g_fp_lane
    assign fp_hit[i] = ext_en_i[i] && (word.width == 3'(i + 1));
  end
  assign fp_ok = |fp_hit;

  always_comb begin
    res_d = '0;
    imm_d = '0;
    if (in_space) begin
      if (fp_width) begin
        if (fp_ok) begin
          res_d.is_fp = 1'b1;
          res_d.size  = word.width;
          res_d.rd    = word.rd;
          res_d.rs1   = word.rs1;
          imm_d = {{(XLEN-IMM_W){instr_i[31]}}, instr_i[31:20]};
        end else begin
          res_d.illegal = 1'b1;
        end
      end else if (vbad) begin
        res_d.illegal = 1'b1;
      end else begin
        res_d.is_vec  = 1'b1;
        res_d.mode    = vmode;
        res_d.size    = {1'b0, eew};
        res_d.nfields = {1'b0, word.nf} + 4'd1;
        res_d.vm      = word.vm;
        res_d.rd      = word.rd;
        res_d.rs1     = word.rs1;
        res_d.rs2     = (word.mop == 2'b00) ? 5'd0 : word.sub;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      imm_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
        imm_q <= imm_d;
      end
    end
  end

  assign valid_o   = valid_q;
  assign is_fp_o   = res_q.is_fp;
  assign is_vec_o  = res_q.is_vec;
  assign illegal_o = res_q.illegal;
  assign mode_o    = res_q.mode;
  assign size_o    = res_q.size;
  assign nfields_o = res_q.nfields;
  assign vm_o      = res_q.vm;
  assign rd_o      = res_q.rd;
  assign rs1_o     = res_q.rs1;
  assign rs2_o     = res_q.rs2;
  assign imm_o     = imm_q;
endmodule

// File: rtl/vfload_decoder_chk.sv
module vfload_decoder_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     instr_i,
  input logic [3:0]      ext_en_i,
  input logic            vec_en_i,
  input logic            valid_o,
  input logic            is_fp_o,
  input logic            is_vec_o,
  input logic            illegal_o,
  input logic [2:0]      mode_o,
  input logic [2:0]      size_o,
  input logic [3:0]      nfields_o,
  input logic            vm_o,
  input logic [4:0]      rd_o,
  input logic [4:0]      rs1_o,
  input logic [4:0]      rs2_o,
  input logic [XLEN-1:0] imm_o
);
  logic in_sp, vec_w;
  assign in_sp = (instr_i[6:0] == 7'b0000111);
  assign vec_w = (instr_i[14:12] == 3'd0) || (instr_i[14:12] >= 3'd5);

  assert_foreign_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !in_sp |=> !is_fp_o && !is_vec_o && !illegal_o);

  assert_fp_no_vec_fields_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_fp_o |-> (mode_o == 3'd0) && (nfields_o == 4'd0) && !vm_o && (rs2_o == 5'd0));

  assert_mew_reserved_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && in_sp && vec_w && instr_i[28] |=> illegal_o);

  assert_mask_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && in_sp && vec_w && (instr_i[27:26] == 2'b00) &&
    (instr_i[24:20] == 5'b01011) && !instr_i[25] |=> illegal_o);

  assert_whole_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && in_sp && vec_w && (instr_i[27:26] == 2'b00) &&
    (instr_i[24:20] == 5'b01000) && !instr_i[25] |=> illegal_o);

  assert_one_class_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({is_fp_o, is_vec_o, illegal_o}));

  assert_valid_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(rd_o) && $stable(illegal_o) && $stable(imm_o));
endmodule

bind vfload_decoder vfload_decoder_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/vfload_decoder_tb.sv
`timescale 1ns/1ps
module vfload_decoder_tb;
  localparam int XLEN = 32;

  typedef struct packed {
    logic       vld;
    logic       is_fp;
    logic       is_vec;
    logic       illegal;
    logic [2:0] mode;
    logic [2:0] size;
    logic [3:0] nf;
    logic       vm;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [31:0] imm;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [3:0] ext_en_i = 4'hF;
  logic vec_en_i = 1'b1;
  logic valid_o, is_fp_o, is_vec_o, illegal_o, vm_o;
  logic [2:0] mode_o, size_o;
  logic [3:0] nfields_o;
  logic [4:0] rd_o, rs1_o, rs2_o;
  logic [XLEN-1:0] imm_o;

  int n_checks = 0;
  int n_fail = 0;
  exp_t exp_cur = '0;

  always #2.5 clk = ~clk;

  vfload_decoder #(.XLEN(XLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .ext_en_i(ext_en_i), .vec_en_i(vec_en_i), .valid_o(valid_o),
    .is_fp_o(is_fp_o), .is_vec_o(is_vec_o), .illegal_o(illegal_o),
    .mode_o(mode_o), .size_o(size_o), .nfields_o(nfields_o), .vm_o(vm_o),
    .rd_o(rd_o), .rs1_o(rs1_o), .rs2_o(rs2_o), .imm_o(imm_o)
  );

  function automatic logic [31:0] mk(int nf, int mew, int mop, int vm, int sub,
                                     int rs1, int w, int rd);
    return {nf[2:0], mew[0], mop[1:0], vm[0], sub[4:0], rs1[4:0], w[2:0], rd[4:0], 7'h07};
  endfunction

  function automatic exp_t model(logic [31:0] ins, logic [3:0] ext, logic ven);
    exp_t e = '0;
    int w = int'(ins[14:12]);
    int nf = int'(ins[31:29]);
    int lu = int'(ins[24:20]);
    int mop = int'(ins[27:26]);
    int vd = int'(ins[11:7]);
    bit vm = ins[25];
    bit bad = 0;
    e.vld = 1'b1;
    if (ins[6:0] != 7'h07) return e;
    if (w >= 1 && w <= 4) begin
      if (!ext[w-1]) begin e.illegal = 1; return e; end
      e.is_fp = 1; e.size = 3'(w); e.rd = ins[11:7]; e.rs1 = ins[19:15];
      e.imm = 32'($signed(ins[31:20]));
      return e;
    end
    if (!ven || ins[28]) bad = 1;
    if (mop == 0) begin
      if (lu == 0) e.mode = 0;
      else if (lu == 16) e.mode = 6;
      else if (lu == 8) begin
        e.mode = 4;
        if (!vm || !(nf == 0 || nf == 1 || nf == 3 || nf == 7) || (vd % (nf + 1)) != 0) bad = 1;
      end else if (lu == 11) begin
        e.mode = 5;
        if (!vm || nf != 0) bad = 1;
      end else bad = 1;
    end else begin
      e.mode = (mop == 1) ? 3'd1 : (mop == 2) ? 3'd2 : 3'd3;
      e.rs2 = ins[24:20];
    end
    if (bad) begin e = '0; e.vld = 1; e.illegal = 1; return e; end
    e.is_vec = 1;
    e.size = (w == 0) ? 3'd0 : 3'(w - 4);
    e.nf = 4'(nf + 1);
    e.vm = vm;
    e.rd = ins[11:7];
    e.rs1 = ins[19:15];
    return e;
  endfunction

  function automatic exp_t actual();
    return {valid_o, is_fp_o, is_vec_o, illegal_o, mode_o, size_o, nfields_o,
            vm_o, rd_o, rs1_o, rs2_o, imm_o};
  endfunction

  task automatic compare(string tag);
    exp_t a = actual();
    n_checks++;
    if (a !== exp_cur) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, a, exp_cur);
    end
  endtask

  task automatic drive(logic v, logic [31:0] ins, logic [3:0] ext, logic ven, string tag);
    @(negedge clk);
    valid_i = v; instr_i = ins; ext_en_i = ext; vec_en_i = ven;
    if (v) exp_cur = model(ins, ext, ven);
    else exp_cur.vld = 1'b0;
    @(negedge clk);
    compare(tag);
    valid_i = 1'b0;
    exp_cur.vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R12 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R12 idle");

    drive(1, 32'h0000_0013, 4'hF, 1, "R1 other opcode");
    drive(1, 32'hE081_5406, 4'hF, 1, "R1 low bits");
    drive(1, mk(7, 1, 3, 1, 31, 3, 2, 1), 4'hF, 1, "R2 flw negative imm mew set");
    drive(1, mk(3, 1, 3, 1, 31, 4, 3, 9), 4'hF, 1, "R2 fld bit28");
    drive(1, mk(0, 0, 0, 0, 12, 5, 4, 2), 4'hF, 1, "R2 flq");
    drive(1, mk(0, 0, 0, 0, 4, 5, 1, 3), 4'hF, 1, "R2 flh");
    drive(1, mk(0, 0, 0, 0, 4, 5, 2, 3), 4'b1101, 1, "R3 single off");
    drive(1, mk(0, 0, 0, 0, 4, 5, 1, 3), 4'b1110, 1, "R3 half off");
    drive(1, mk(0, 0, 0, 0, 4, 5, 4, 3), 4'b0111, 1, "R3 quad off");
    for (int w = 0; w < 8; w++)
      if (w == 0 || w >= 5) drive(1, mk(1, 0, 0, 1, 0, 6, w, 4), 4'hF, 1, "R4 eew");
    drive(1, mk(0, 0, 0, 1, 0, 6, 6, 4), 4'hF, 0, "R4 vec off");
    drive(1, mk(0, 1, 0, 1, 0, 6, 5, 4), 4'hF, 1, "R5 mew");
    drive(1, mk(0, 1, 2, 1, 7, 6, 0, 4), 4'hF, 1, "R5 mew strided");
    drive(1, mk(2, 0, 1, 0, 9, 6, 7, 4), 4'hF, 1, "R6 idx unord");
    drive(1, mk(0, 0, 2, 1, 9, 6, 5, 4), 4'hF, 1, "R6 strided");
    drive(1, mk(0, 0, 3, 1, 9, 6, 6, 4), 4'hF, 1, "R6 idx ord");
    drive(1, mk(0, 0, 0, 0, 16, 6, 6, 4), 4'hF, 1, "R7 fof");
    drive(1, mk(0, 0, 0, 1, 1, 6, 6, 4), 4'hF, 1, "R7 bad sub");
    drive(1, 32'hE081_5407, 4'hF, 1, "R8 whole masked");
    drive(1, 32'hE281_5407, 4'hF, 1, "R8 whole x8 vd8");
    drive(1, mk(2, 0, 0, 1, 8, 2, 5, 0), 4'hF, 1, "R8 nf2");
    drive(1, mk(3, 0, 0, 1, 8, 2, 5, 6), 4'hF, 1, "R8 misaligned");
    drive(1, mk(3, 0, 0, 1, 8, 2, 5, 4), 4'hF, 1, "R8 aligned");
    drive(1, 32'h20B0_0087, 4'hF, 1, "R9 mask masked seg");
    drive(1, 32'h02B0_0087, 4'hF, 1, "R9 mask legal");
    drive(1, mk(1, 0, 0, 1, 11, 0, 0, 1), 4'hF, 1, "R9 mask seg");
    drive(1, mk(0, 0, 0, 1, 11, 0, 0, 1), 4'hF, 1, "R10 legal before illegal");
    drive(1, mk(0, 0, 0, 1, 2, 9, 0, 1), 4'hF, 1, "R10 illegal zeros fields");
    drive(1, mk(0, 0, 2, 1, 9, 6, 5, 4), 4'hF, 1, "R11 load");
    drive(0, 32'h0000_0007, 4'hF, 1, "R11 hold");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      if (i % 2 == 0) r[6:0] = 7'h07;
      drive(($urandom % 4) != 0, r, 4'($urandom), ($urandom % 5) != 0, "R10 random");
    end

    @(negedge clk);
    valid_i = 1'b1; instr_i = 32'h02B0_0087;
    @(negedge clk);
    #1 rst_ni = 1'b0;
    exp_cur = '0;
    valid_i = 1'b0;
    #1 compare("R12 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    drive(1, mk(0, 0, 0, 1, 8, 1, 6, 3), 4'hF, 1, "R12 after reset");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule